// File: doc/BRIEF.md
# Expansion Card Configuration Responder

This block lets a plug-in expansion card take part in the host's automatic configuration sequence. After reset the card is unconfigured. It answers only in a 128-byte identification window, and it sees only the low 16 address bits. Each logical identification byte is stored as two nibbles. Each nibble is returned in bits 7:4 of its own byte location, four bytes apart. Most nibbles come back inverted. Two reserved entries come back true.

The host then does one of two things. It can assign a base address in two writes: a byte write of the low part, then a word write of the high part that commits the address. Or it can send a shut-up byte write, which retires the card without giving it an address. Either way the card becomes configured and raises its chain output, so the next card in the daisy chain can take its turn. From then on the card stops answering in the identification window. It drives a 24-bit offset mask so that later logic can decode a 16 MB window.

Top module: `acfg_responder`

## Requirements
- R1: After a synchronous active-low reset: cfg_done=0, chain_out=0, base_valid=0, base_addr=0x0000, bus_rdata=0x0000, offset_mask=0x00FFFF.
- R2: Logical identification byte n (n from 0 to 31) returns its high nibble in bits 7:4 of offset 4n and its low nibble in bits 7:4 of offset 4n+2.
- R3: Logical bytes 0 and 16 (offsets 0x00, 0x02, 0x40, 0x42) read as {nibble, 4'h0}. Every other programmed byte reads as {~nibble, 4'hF}.
- R4: While unconfigured, these read as 0xFF: odd offsets below 128, and offsets of logical bytes at or beyond ID_COUNT. Offsets from 128 to 0xFFFF read as 0x00. Address bits 23:16 are ignored.
- R5: A read returns its data on bus_rdata one clock after bus_rd is sampled. A byte read is zero-extended to 16 bits. A word read returns the byte at the even address in bits 15:8 and the byte at the odd address in bits 7:0. bus_rdata holds its value in cycles without a read.
- R6: While unconfigured, a byte write to offset 0x48 latches wdata[7:0] as the low base part. The latest such write wins, and no output changes.
- R7: While unconfigured, a word write to offset 0x44 sets base_addr = {wdata[15:8], 4'h0, low[7:4]}. In the next cycle base_valid=1 and cfg_done=1.
- R8: While unconfigured, a byte write to offset 0x4C sets cfg_done=1. base_valid stays 0 and base_addr stays 0x0000.
- R9: chain_out rises on the same edge as cfg_done and stays high until reset.
- R10: While unconfigured, every other write has no effect. This covers a byte write to 0x44, a word write to 0x4C or 0x48, and writes at any other offset.
- R11: Once configured: offset_mask=0xFFFFFF, board_offset = bus_addr & offset_mask, reads return 0x0000, and configuration writes change nothing.
- R12: When a read and a committing write are sampled in the same cycle, the read returns identification data from the state before the write.
- R13: When reset and a configuration write are sampled in the same cycle, reset wins and the card stays unconfigured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Read strobe, sampled each clock |
| bus_wr | input | 1 | Write strobe, sampled each clock |
| bus_word | input | 1 | 1 = word access, 0 = byte access |
| bus_addr | input | 24 | Byte address within the card's space |
| bus_wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| bus_rdata | output | 16 | Registered read data |
| cfg_done | output | 1 | Card configured (address assigned or shut up) |
| base_valid | output | 1 | base_addr holds an assigned address |
| base_addr | output | 16 | Assigned base, address bits 31:16 |
| chain_out | output | 1 | Daisy-chain enable for the next card |
| offset_mask | output | 24 | Address mask in use: 16 bits before configuration, 24 after |
| board_offset | output | 24 | bus_addr masked by offset_mask |

## Verification
Two functions can fall in the same cycle. One is the registered read of the identification space. The other is the configuration commit that shuts that space off. The bench raises bus_rd and a committing word write to 0x44 together. Its reference model computes the read from the pre-write state, so it expects 0xFFFF rather than 0x0000. In the next cycle it expects cfg_done, base_valid and the new base. A second collision holds reset low during a commit write; the model then expects every output in its reset value.

// File: rtl/acfg_pkg.sv
// Shared types and helpers for the configuration responder.
// Assumes byte-addressed host accesses with at most 16-bit data.
package acfg_pkg;

    // Kind of configuration access decoded from one write
    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_LOLAT  = 2'd1,
        ACC_COMMIT = 2'd2,
        ACC_SHUTUP = 2'd3
    } acc_kind_e;

    // Offsets that carry behaviour during configuration
    localparam logic [15:0] OFF_COMMIT = 16'h0044;
    localparam logic [15:0] OFF_LOLAT  = 16'h0048;
    localparam logic [15:0] OFF_SHUTUP = 16'h004C;

    // Encode one nibble into the byte the host sees
    function automatic logic [7:0] nib_to_byte(input logic [3:0] nib, input logic keep_true);
        nib_to_byte = keep_true ? {nib, 4'h0} : {~nib, 4'hF};
    endfunction

endpackage

// File: rtl/acfg_id_rom.sv
// Identification space lookup.
// Builds a table of encoded nibbles from the ID_DATA parameter and answers
// two offsets at once (the even and the odd byte of a word).
// Assumes offsets are already reduced to the pre-configuration address width.
module acfg_id_rom
    import acfg_pkg::*;
#(
    parameter int unsigned ID_COUNT    = 17,
    parameter logic [ID_COUNT*8-1:0] ID_DATA = '0,
    parameter int unsigned SPACE_BYTES = 128,
    parameter int unsigned OFF_W       = 16,
    parameter int unsigned TRUE_SLOT_A = 0,
    parameter int unsigned TRUE_SLOT_B = 16
) (
    input  logic [1:0][OFF_W-1:0] off_i,
    output logic [1:0][7:0]       byte_o
);
    localparam int unsigned SLOTS = SPACE_BYTES / 4;
    localparam int unsigned IDX_W = $clog2(SLOTS);

    logic [7:0] hi_tab [SLOTS];
    logic [7:0] lo_tab [SLOTS];

    // Fill the nibble tables; slots without a programmed byte read as all ones
    for (genvar n = 0; n < SLOTS; n++) begin : g_slot
        if (n < ID_COUNT) begin : g_prog
            localparam bit KEEP = (n == TRUE_SLOT_A) || (n == TRUE_SLOT_B);
            assign hi_tab[n] = nib_to_byte(ID_DATA[8*n+4 +: 4], KEEP);
            assign lo_tab[n] = nib_to_byte(ID_DATA[8*n   +: 4], KEEP);
        end else begin : g_blank
            assign hi_tab[n] = 8'hFF;
            assign lo_tab[n] = 8'hFF;
        end
    end

    // One lookup per port
    for (genvar p = 0; p < 2; p++) begin : g_port
        logic [IDX_W-1:0] idx;
        assign idx = off_i[p][IDX_W+1:2];

        // Select the encoded byte for this offset, or zero past the window
        always_comb begin
            if (off_i[p] >= OFF_W'(SPACE_BYTES)) begin
                byte_o[p] = 8'h00;
            end else begin
                unique case (off_i[p][1:0])
                    2'd0:    byte_o[p] = hi_tab[idx];
                    2'd2:    byte_o[p] = lo_tab[idx];
                    default: byte_o[p] = 8'hFF;
                endcase
            end
        end
    end

endmodule

// File: rtl/acfg_reg_ctrl.sv
// Configuration state: low-part latch, base commit, shut-up and chain.
// Assumes at most one write per clock; writes are ignored once configured.
module acfg_reg_ctrl
    import acfg_pkg::*;
#(
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned BASE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              word_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [15:0]       wdata_i,
    output logic              cfg_done_o,
    output logic              base_valid_o,
    output logic [BASE_W-1:0] base_o,
    output logic              chain_o
);
    localparam int unsigned PAD_W = BASE_W - 12;

    acc_kind_e kind;
    logic [7:0] lo_q;

    // Classify the current write by size and offset
    always_comb begin
        kind = ACC_NONE;
        if (wr_i && !cfg_done_o) begin
            if (!word_i && off_i == OFF_W'(OFF_LOLAT))       kind = ACC_LOLAT;
            else if (word_i && off_i == OFF_W'(OFF_COMMIT))  kind = ACC_COMMIT;
            else if (!word_i && off_i == OFF_W'(OFF_SHUTUP)) kind = ACC_SHUTUP;
        end
    end

    // Hold the most recent low base part
    always_ff @(posedge clk) begin
        if (!rst_n)                lo_q <= 8'h00;
        else if (kind == ACC_LOLAT) lo_q <= wdata_i[7:0];
    end

    // Commit the base address from the high byte and the latched low part
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o       <= '0;
            base_valid_o <= 1'b0;
        end else if (kind == ACC_COMMIT) begin
            base_o       <= {wdata_i[15:8], PAD_W'(0), lo_q[7:4]};
            base_valid_o <= 1'b1;
        end
    end

    // Mark the card configured on commit or shut-up
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_done_o <= 1'b0;
        else if (kind == ACC_COMMIT || kind == ACC_SHUTUP) cfg_done_o <= 1'b1;
    end

    // Enable the next card; only reset clears it
    always_ff @(posedge clk) begin
        if (!rst_n) chain_o <= 1'b0;
        else if (kind == ACC_COMMIT || kind == ACC_SHUTUP) chain_o <= 1'b1;
    end

endmodule

// File: rtl/acfg_rd_path.sv
// Registered read data for byte and word accesses.
// Assumes the two lookup bytes belong to the even and odd address of the access.
module acfg_rd_path #(
    parameter int unsigned OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_i,
    input  logic             word_i,
    input  logic             odd_i,
    input  logic             cfg_done_i,
    input  logic [1:0][7:0]  byte_i,
    output logic [15:0]      rdata_o
);
    logic [15:0] rd_next;

    // Assemble the returned value from the lookup bytes
    always_comb begin
        if (cfg_done_i)  rd_next = 16'h0000;
        else if (word_i) rd_next = {byte_i[0], byte_i[1]};
        else             rd_next = {8'h00, byte_i[odd_i]};
    end

    // Capture the value on a read; hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_o <= 16'h0000;
        else if (rd_i) rdata_o <= rd_next;
    end

endmodule

// File: rtl/acfg_responder.sv
// Top of the configuration responder.
// Reduces the address to 16 bits before configuration and to 24 after;
// decoding of normal board space is left to the logic that uses board_offset.
module acfg_responder #(
    parameter int unsigned ADDR_W      = 24,
    parameter int unsigned OFF_W       = 16,
    parameter int unsigned BASE_W      = 16,
    parameter int unsigned SPACE_BYTES = 128,
    parameter int unsigned ID_COUNT    = 17,
    parameter logic [ID_COUNT*8-1:0] ID_DATA = {
        8'h00, 8'hA8, 8'h70, 8'h0F, 8'hE5, 8'h39, 8'h82, 8'h6D, 8'h44,
        8'h1B, 8'hF0, 8'h93, 8'h07, 8'h00, 8'h5E, 8'h2A, 8'hC1}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_word,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              cfg_done,
    output logic              base_valid,
    output logic [BASE_W-1:0] base_addr,
    output logic              chain_out,
    output logic [ADDR_W-1:0] offset_mask,
    output logic [ADDR_W-1:0] board_offset
);
    localparam logic [ADDR_W-1:0] MASK_PRE  = ADDR_W'({OFF_W{1'b1}});
    localparam logic [ADDR_W-1:0] MASK_POST = {ADDR_W{1'b1}};

    logic [OFF_W-1:0]      off;
    logic [1:0][OFF_W-1:0] look_off;
    logic [1:0][7:0]       look_byte;

    assign off         = bus_addr[OFF_W-1:0];
    assign look_off[0] = {off[OFF_W-1:1], 1'b0};
    assign look_off[1] = {off[OFF_W-1:1], 1'b1};

    // Address mask tracks the configuration state
    assign offset_mask  = cfg_done ? MASK_POST : MASK_PRE;
    assign board_offset = bus_addr & offset_mask;

    acfg_id_rom #(
        .ID_COUNT   (ID_COUNT),
        .ID_DATA    (ID_DATA),
        .SPACE_BYTES(SPACE_BYTES),
        .OFF_W      (OFF_W)
    ) i_rom (
        .off_i (look_off),
        .byte_o(look_byte)
    );

    acfg_reg_ctrl #(
        .OFF_W (OFF_W),
        .BASE_W(BASE_W)
    ) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (bus_wr),
        .word_i      (bus_word),
        .off_i       (off),
        .wdata_i     (bus_wdata),
        .cfg_done_o  (cfg_done),
        .base_valid_o(base_valid),
        .base_o      (base_addr),
        .chain_o     (chain_out)
    );

    acfg_rd_path #(
        .OFF_W(OFF_W)
    ) i_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_i      (bus_rd),
        .word_i    (bus_word),
        .odd_i     (off[0]),
        .cfg_done_i(cfg_done),
        .byte_i    (look_byte),
        .rdata_o   (bus_rdata)
    );

endmodule

// File: rtl/acfg_checker.sv
// Property checker for the configuration responder, attached by bind.
module acfg_checker #(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned BASE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              bus_word,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic [15:0]       bus_rdata,
    input logic              cfg_done,
    input logic              base_valid,
    input logic [BASE_W-1:0] base_addr,
    input logic              chain_out,
    input logic [ADDR_W-1:0] offset_mask
);
    logic [OFF_W-1:0] off;
    assign off = bus_addr[OFF_W-1:0];

    p_chain_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        chain_out |=> chain_out);

    p_chain_with_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        chain_out == cfg_done);

    p_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_done && bus_wr && bus_word && off == OFF_W'(16'h0044))
        |=> (cfg_done && base_valid && base_addr[BASE_W-1:BASE_W-8] == $past(bus_wdata[15:8])));

    p_shutup_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_done && bus_wr && !bus_word && off == OFF_W'(16'h004C))
        |=> (cfg_done && !base_valid));

    p_valid_needs_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        base_valid |-> cfg_done);

    p_frozen_after_cfg_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> ($stable(base_addr) && $stable(base_valid)));

    p_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        offset_mask == (cfg_done ? {ADDR_W{1'b1}} : ADDR_W'({OFF_W{1'b1}})));

    p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    p_cfg_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && bus_rd) |=> (bus_rdata == 16'h0000));

endmodule

bind acfg_responder acfg_checker #(
    .ADDR_W(ADDR_W),
    .OFF_W (OFF_W),
    .BASE_W(BASE_W)
) i_acfg_checker (.*);

// File: tb/test_acfg_responder.sv
// Bench: behavioural reference model compared with the design every clock.
module test_acfg_responder;

    localparam int ID_N = 17;
    localparam logic [ID_N*8-1:0] TB_ID = {
        8'h00, 8'hA8, 8'h70, 8'h0F, 8'hE5, 8'h39, 8'h82, 8'h6D, 8'h44,
        8'h1B, 8'hF0, 8'h93, 8'h07, 8'h00, 8'h5E, 8'h2A, 8'hC1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_word = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        cfg_done, base_valid, chain_out;
    logic [15:0] base_addr;
    logic [23:0] offset_mask, board_offset;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // Reference model state
    int m_cfg = 0, m_bv = 0, m_base = 0, m_lo = 0, m_chain = 0, m_rdata = 0;

    always #10 clk = ~clk;

    acfg_responder #(.ID_COUNT(ID_N), .ID_DATA(TB_ID)) i_acfg_responder (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cfg_done(cfg_done), .base_valid(base_valid),
        .base_addr(base_addr), .chain_out(chain_out),
        .offset_mask(offset_mask), .board_offset(board_offset));

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic int id_byte(input int n);
        id_byte = int'(TB_ID[8*n +: 8]);
    endfunction

    // Expected byte seen by the host at a 16-bit offset while unconfigured
    function automatic int exp_byte(input int a);
        int n, sub, v, nib;
        if (a >= 128) return 0;
        n = a / 4;
        sub = a % 4;
        if (sub == 1 || sub == 3) return 'hFF;
        if (n >= ID_N) return 'hFF;
        v = id_byte(n);
        nib = (sub == 2) ? (v % 16) : (v / 16);
        if (n == 0 || n == 16) return nib * 16;
        return (15 - nib) * 16 + 15;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, advance the model, compare at the next falling edge
    task automatic cyc(input bit rst, input bit rd, input bit wr, input bit word,
                       input int addr, input int wdata, input string tag);
        int a16, even, mask;
        rst_n = ~rst; bus_rd = rd; bus_wr = wr; bus_word = word;
        bus_addr = 24'(addr); bus_wdata = 16'(wdata);
        a16 = addr % 65536;
        if (rst) begin
            m_cfg = 0; m_bv = 0; m_base = 0; m_lo = 0; m_chain = 0; m_rdata = 0;
        end else begin
            if (rd) begin
                even = a16 - (a16 % 2);
                if (m_cfg != 0) m_rdata = 0;
                else if (word) m_rdata = exp_byte(even) * 256 + exp_byte(even + 1);
                else m_rdata = exp_byte(a16);
            end
            if (wr && m_cfg == 0) begin
                if (!word && a16 == 'h48) m_lo = wdata % 256;
                else if (word && a16 == 'h44) begin
                    m_base = (wdata / 256) * 256 + m_lo / 16;
                    m_bv = 1; m_cfg = 1; m_chain = 1;
                end else if (!word && a16 == 'h4C) begin
                    m_cfg = 1; m_chain = 1;
                end
            end
        end
        @(negedge clk);
        mask = (m_cfg != 0) ? 'hFFFFFF : 'hFFFF;
        chk({tag, " rdata"}, int'(bus_rdata), m_rdata);
        chk({tag, " cfg_done"}, int'(cfg_done), m_cfg);
        chk({tag, " base_valid"}, int'(base_valid), m_bv);
        chk({tag, " base_addr"}, int'(base_addr), m_base);
        chk("R9 chain_out", int'(chain_out), m_chain);
        chk("R11 offset_mask", int'(offset_mask), mask);
        chk("R11 board_offset", int'(board_offset), (addr % 'h1000000) & mask);
    endtask

    initial begin
        @(negedge clk);
        cyc(1, 0, 0, 0, 0, 0, "R1");
        cyc(1, 1, 1, 1, 'h44, 'hFFFF, "R1");
        cyc(0, 0, 0, 0, 0, 0, "R1");
        // Identification reads
        cyc(0, 1, 0, 0, 'h00, 0, "R3");
        cyc(0, 1, 0, 0, 'h02, 0, "R3");
        cyc(0, 1, 0, 0, 'h04, 0, "R2");
        cyc(0, 1, 0, 0, 'h06, 0, "R2");
        cyc(0, 1, 0, 0, 'h24, 0, "R2");
        cyc(0, 1, 0, 0, 'h40, 0, "R3");
        cyc(0, 1, 0, 0, 'h42, 0, "R3");
        cyc(0, 1, 0, 0, 'h3C, 0, "R3");
        cyc(0, 1, 0, 0, 'h01, 0, "R4");
        cyc(0, 1, 0, 0, 'h50, 0, "R4");
        cyc(0, 1, 0, 0, 'h80, 0, "R4");
        cyc(0, 1, 0, 0, 'h1234, 0, "R4");
        cyc(0, 1, 0, 0, 'hAB0004, 0, "R4");
        cyc(0, 1, 0, 1, 'h08, 0, "R5");
        cyc(0, 1, 0, 1, 'h0B, 0, "R5");
        cyc(0, 0, 0, 0, 'h00, 0, "R5");
        // Writes that must be ignored
        cyc(0, 0, 1, 0, 'h44, 'h00EE, "R10");
        cyc(0, 0, 1, 1, 'h4C, 'h1234, "R10");
        cyc(0, 0, 1, 1, 'h48, 'h5566, "R10");
        cyc(0, 0, 1, 0, 'h10, 'h00AA, "R10");
        cyc(0, 1, 0, 0, 'h10, 0, "R10");
        // Low part latch, reset colliding with commit
        cyc(0, 0, 1, 0, 'h48, 'h00A7, "R6");
        cyc(0, 0, 1, 0, 'h48, 'h003C, "R6");
        cyc(1, 0, 1, 1, 'h44, 'h7700, "R13");
        cyc(0, 0, 0, 0, 0, 0, "R13");
        // Commit with a read in the same cycle
        cyc(0, 0, 1, 0, 'h48, 'h00C9, "R6");
        cyc(0, 1, 1, 1, 'h44, 'h5B00, "R12");
        cyc(0, 1, 0, 0, 'h00, 0, "R11");
        cyc(0, 1, 0, 1, 'h40, 0, "R11");
        cyc(0, 0, 1, 1, 'h44, 'h1100, "R11");
        cyc(0, 0, 1, 0, 'h4C, 'h0000, "R11");
        cyc(0, 0, 0, 0, 'hABCDEF, 0, "R11");
        cyc(0, 0, 0, 0, 0, 0, "R9");
        // Shut-up path
        cyc(1, 0, 0, 0, 0, 0, "R1");
        cyc(0, 0, 1, 0, 'h48, 'h00F0, "R6");
        cyc(0, 0, 1, 0, 'h4C, 'h0000, "R8");
        cyc(0, 0, 1, 1, 'h44, 'h2200, "R8");
        cyc(0, 1, 0, 0, 'h02, 0, "R8");
        cyc(0, 0, 0, 0, 'h123456, 0, "R9");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule